// File: doc/BRIEF.md
# Reference Clock Rate and Activity Monitor

This block watches a single incoming reference clock with a much faster, free-running system clock. The reference passes through a multi-stage synchronizer. Only its rising edges are used. The number of system-clock cycles between consecutive rising edges is the measured period.

Each measured period is compared against a table of seven nominal telecom rates. The matching rate becomes a 3-bit code once two consecutive periods agree. From the confirmed rate the block also derives the limits for two independent health checks:

- **Coarse check.** For fast rates it counts edges in a fixed window of system cycles. For the two frame-rate references, where the window would hold no edges, it checks each period against the nominal band instead.
- **Single-cycle check.** It flags a period that is badly short or long, and it flags a reference that has stopped entirely.

One copy is placed per reference input, with no state shared between copies. The code and valid bit feed the other monitors and a downstream phase detector.

Top module: `refclk_monitor`

## Requirements
- R1: After reset, `code_o` is 0, `valid_o` is 0 and both fail flags are 0.
- R2: A period is the count of system cycles between two consecutive synchronized rising edges of `ref_i`. A high phase of a single system cycle is still detected as an edge.
- R3: A period lies in the band of rate i when it is within nominal ± nominal/8 (integer). The code is i+1, with 1 = 2 kHz, 2 = 8 kHz, 3 = 1.544 MHz, 4 = 2.048 MHz, 5 = 8.192 MHz, 6 = 16.384 MHz, 7 = 19.44 MHz. A period that matches no band leaves `code_o` unchanged.
- R4: `code_o` and `valid_o` update only when two consecutive measured periods fall in the same nonzero band. `valid_o` is 1 exactly when `code_o` is nonzero.
- R5: The coarse check uses a window when `WIN_CYC` ≥ 8 × nominal. In that case the edge count of each `WIN_CYC`-cycle window must lie within E ± E/8, where E = `WIN_CYC`/nominal; a count outside this range sets `coarse_fail_o`.
- R6: For rates whose nominal period is too long for the window, the coarse check sets `coarse_fail_o` on any measured period outside the rate's band.
- R7: While valid, a measured period below nominal/2 or above 1.5 × nominal sets `cycle_fail_o`.
- R8: The running count reaches a limit without a rising edge. The limit is 2 × nominal while valid, and 2 × the longest table period otherwise. When it is reached, `cycle_fail_o` sets, `code_o` goes to 0, `valid_o` goes to 0, and detection restarts from scratch.
- R9: A set fail flag clears only after 4 consecutive good measurements of its own kind.
- R10: The two fail flags are independent: a fault seen by only one check leaves the other flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Asynchronous reference clock under test |
| code_o | output | 3 | Detected rate code, 0 when unknown |
| valid_o | output | 1 | Rate code confirmed |
| coarse_fail_o | output | 1 | Coarse frequency deviation flag |
| cycle_fail_o | output | 1 | Single period hit or loss-of-clock flag |

## Verification
The bench runs with a scaled period table so that all seven rates fit in a short run. It targets the following cases:

- **One-cycle-high pulse.** A synchronizer that misses it would never detect the fastest rate.
- **First measured period after a loss.** A design that confirms on one period, or that measures the stale gap, would raise `valid_o` too early.
- **Clearing a fail flag.** It is probed one good period before and one good period after the fourth, which exposes an off-by-one in the good-run counter.
- **Independence of the checks.** A 25 % slow fast-rate reference must trip only the window check. A single 67 % long period must trip only the single-cycle check. A 20 % slow frame-rate reference must trip the period-based fallback. A design that mixes up the thresholds would raise the wrong flag or keep a wrong code.

// File: rtl/refclk_monitor_pkg.sv
package refclk_monitor_pkg;
  localparam int unsigned N_RATES  = 7;
  localparam int unsigned CODE_W   = 3;
  localparam int unsigned BAND_DIV = 8;  // +-12.5 % acceptance
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_NONE = '0;
endpackage

// File: rtl/refmon_edge.sv
module refmon_edge #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             rise_o,
  output logic             per_vld_o,
  output logic [CNT_W-1:0] per_o,
  output logic             lost_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o    = sync_q[SYNC_STAGES-1] & ~last_q;
  assign per_vld_o = rise_o & seen_q;
  assign per_o     = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
  assign lost_o    = !rise_o && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (rise_o) begin
      cnt_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (lost_o) seen_q <= 1'b0;  // gap after a loss is not a period
    end
  end
endmodule

// File: rtl/refmon_class.sv
module refmon_class import refclk_monitor_pkg::*; #(
  parameter int unsigned PER_TAB [N_RATES] = '{100000, 25000, 130, 98, 24, 12, 10},
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_vld_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic             lost_i,
  output code_t            code_o,
  output logic             valid_o,
  output logic             chg_o
);
  code_t cls, cand_q, code_q;
  logic  valid_q;

  // later entries (faster rates) win where bands touch
  always_comb begin
    cls = CODE_NONE;
    for (int i = 0; i < N_RATES; i++) begin
      if (per_i >= CNT_W'(PER_TAB[i] - PER_TAB[i] / BAND_DIV) &&
          per_i <= CNT_W'(PER_TAB[i] + PER_TAB[i] / BAND_DIV))
        cls = CODE_W'(i + 1);
    end
  end

  assign chg_o = per_vld_i && (cls != CODE_NONE) && (cls == cand_q) && (cls != code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= CODE_NONE;
      code_q  <= CODE_NONE;
      valid_q <= 1'b0;
    end else if (lost_i) begin
      cand_q  <= CODE_NONE;
      code_q  <= CODE_NONE;
      valid_q <= 1'b0;
    end else if (per_vld_i) begin
      cand_q <= cls;
      if (cls != CODE_NONE && cls == cand_q) begin
        code_q  <= cls;
        valid_q <= 1'b1;
      end
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/refmon_coarse.sv
module refmon_coarse import refclk_monitor_pkg::*; #(
  parameter int unsigned PER_TAB [N_RATES] = '{100000, 25000, 130, 98, 24, 12, 10},
  parameter int unsigned WIN_CYC  = 6000,
  parameter int unsigned GOOD_RUN = 4,
  parameter int unsigned CNT_W    = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             per_vld_i,
  input  logic [CNT_W-1:0] per_i,
  input  code_t            code_i,
  input  logic             valid_i,
  input  logic             chg_i,
  output logic             eval_o,
  output logic             fail_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYC + 1);
  localparam int unsigned GR_W  = $clog2(GOOD_RUN + 1);

  logic             use_win;
  logic [WIN_W-1:0] e_lo, e_hi, wcnt_q, ecnt_q, ecnt_nxt;
  logic [CNT_W-1:0] b_lo, b_hi;
  logic             win_end, win_eval, per_eval, ok;
  logic [GR_W-1:0]  good_q;
  logic             fail_q;

  always_comb begin
    use_win = 1'b0;
    e_lo = '0; e_hi = '0; b_lo = '0; b_hi = '0;
    for (int i = 0; i < N_RATES; i++) begin
      if (code_i == CODE_W'(i + 1)) begin
        use_win = (WIN_CYC >= 8 * PER_TAB[i]);
        e_lo = WIN_W'(WIN_CYC / PER_TAB[i] - (WIN_CYC / PER_TAB[i]) / BAND_DIV);
        e_hi = WIN_W'(WIN_CYC / PER_TAB[i] + (WIN_CYC / PER_TAB[i]) / BAND_DIV);
        b_lo = CNT_W'(PER_TAB[i] - PER_TAB[i] / BAND_DIV);
        b_hi = CNT_W'(PER_TAB[i] + PER_TAB[i] / BAND_DIV);
      end
    end
  end

  assign win_end  = (wcnt_q == WIN_W'(WIN_CYC - 1));
  assign ecnt_nxt = ecnt_q + {{(WIN_W-1){1'b0}}, rise_i};
  assign win_eval = valid_i && !chg_i && win_end && use_win;
  assign per_eval = valid_i && !chg_i && per_vld_i && !use_win;
  assign eval_o   = win_eval || per_eval;
  assign ok       = use_win ? (ecnt_nxt >= e_lo && ecnt_nxt <= e_hi)
                            : (per_i >= b_lo && per_i <= b_hi);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else if (!valid_i || chg_i || win_end) begin
      wcnt_q <= '0;
      ecnt_q <= '0;
    end else begin
      wcnt_q <= wcnt_q + 1'b1;
      ecnt_q <= ecnt_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      good_q <= '0;
    end else if (eval_o) begin
      if (!ok) begin
        fail_q <= 1'b1;
        good_q <= '0;
      end else if (fail_q) begin
        if (good_q == GR_W'(GOOD_RUN - 1)) begin
          fail_q <= 1'b0;
          good_q <= '0;
        end else good_q <= good_q + 1'b1;
      end
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/refmon_cycle.sv
module refmon_cycle #(
  parameter int unsigned GOOD_RUN = 4,
  parameter int unsigned CNT_W    = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             per_vld_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] nom_i,
  input  logic             valid_i,
  input  logic             chg_i,
  input  logic             lost_i,
  output logic             fail_o
);
  localparam int unsigned GR_W = $clog2(GOOD_RUN + 1);

  logic            eval, bad;
  logic [GR_W-1:0] good_q;
  logic            fail_q;

  assign eval = per_vld_i && valid_i && !chg_i;
  assign bad  = (per_i < (nom_i >> 1)) || (per_i > nom_i + (nom_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= 1'b0;
      good_q <= '0;
    end else if (lost_i || (eval && bad)) begin
      fail_q <= 1'b1;
      good_q <= '0;
    end else if (eval && fail_q) begin
      if (good_q == GR_W'(GOOD_RUN - 1)) begin
        fail_q <= 1'b0;
        good_q <= '0;
      end else good_q <= good_q + 1'b1;
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/refclk_monitor.sv
module refclk_monitor import refclk_monitor_pkg::*; #(
  // nominal periods in system cycles, longest first (2 kHz .. 19.44 MHz)
  parameter int unsigned PER_TAB [N_RATES] = '{100000, 25000, 130, 98, 24, 12, 10},
  parameter int unsigned WIN_CYC     = 6000,
  parameter int unsigned GOOD_RUN    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  output logic [2:0] code_o,
  output logic       valid_o,
  output logic       coarse_fail_o,
  output logic       cycle_fail_o
);
  localparam int unsigned CNT_W = $clog2(2 * PER_TAB[0] + 2);

  logic             rise, per_vld, lost, chg, cf_eval;
  logic [CNT_W-1:0] per, nom, lim;
  code_t            code;

  always_comb begin
    nom = '0;
    for (int i = 0; i < N_RATES; i++)
      if (code == CODE_W'(i + 1)) nom = CNT_W'(PER_TAB[i]);
  end

  assign lim = valid_o ? {nom[CNT_W-2:0], 1'b0} : CNT_W'(2 * PER_TAB[0]);

  refmon_edge #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_i(ref_i), .lim_i(lim),
    .rise_o(rise), .per_vld_o(per_vld), .per_o(per), .lost_o(lost)
  );

  refmon_class #(.PER_TAB(PER_TAB), .CNT_W(CNT_W)) u_class (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_vld_i(per_vld), .per_i(per),
    .lost_i(lost), .code_o(code), .valid_o(valid_o), .chg_o(chg)
  );

  refmon_coarse #(.PER_TAB(PER_TAB), .WIN_CYC(WIN_CYC), .GOOD_RUN(GOOD_RUN),
                  .CNT_W(CNT_W)) u_coarse (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .per_vld_i(per_vld),
    .per_i(per), .code_i(code), .valid_i(valid_o), .chg_i(chg),
    .eval_o(cf_eval), .fail_o(coarse_fail_o)
  );

  refmon_cycle #(.GOOD_RUN(GOOD_RUN), .CNT_W(CNT_W)) u_cycle (
    .clk_i(clk_i), .rst_ni(rst_ni), .per_vld_i(per_vld), .per_i(per),
    .nom_i(nom), .valid_i(valid_o), .chg_i(chg), .lost_i(lost),
    .fail_o(cycle_fail_o)
  );

  assign code_o = code;
endmodule

// File: rtl/refclk_monitor_chk.sv
module refclk_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] code_i,
  input logic       valid_i,
  input logic       cf_i,
  input logic       sc_i,
  input logic       rise_i,
  input logic       per_vld_i,
  input logic       lost_i,
  input logic       cf_eval_i
);
  a_r2_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !rise_i);

  a_r4_valid_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i == (code_i != 3'd0));

  a_r4_code_moves_on_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_i) |-> $past(per_vld_i || lost_i));

  a_r8_loss_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |=> (!valid_i && sc_i && code_i == 3'd0));

  a_r9_sc_clears_on_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sc_i) |-> $past(per_vld_i));

  a_r5_cf_sets_on_eval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cf_i) |-> $past(cf_eval_i));
endmodule

bind refclk_monitor refclk_monitor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_o), .valid_i(valid_o),
  .cf_i(coarse_fail_o), .sc_i(cycle_fail_o), .rise_i(rise),
  .per_vld_i(per_vld), .lost_i(lost), .cf_eval_i(cf_eval)
);

// File: tb/refclk_monitor_test.sv
module refclk_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 190000;

  typedef struct packed {
    int         per;
    int         hi;
    logic [2:0] code;
  } vec_t;

  // scaled table: 2000,500,64,48,24,16,12 cycles, window 960
  localparam vec_t VEC [7] = '{
    '{per: 2000, hi: 1000, code: 3'd1},
    '{per: 500,  hi: 250,  code: 3'd2},
    '{per: 64,   hi: 32,   code: 3'd3},
    '{per: 48,   hi: 24,   code: 3'd4},
    '{per: 24,   hi: 12,   code: 3'd5},
    '{per: 16,   hi: 8,    code: 3'd6},
    '{per: 12,   hi: 1,    code: 3'd7}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_in = 1'b0;
  logic [2:0] code;
  logic       valid, cf, sc;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_monitor #(
    .PER_TAB('{2000, 500, 64, 48, 24, 16, 12}),
    .WIN_CYC(960)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_in),
    .code_o(code), .valid_o(valid), .coarse_fail_o(cf), .cycle_fail_o(sc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input int per, input int hi, input int n);
    for (int k = 0; k < n; k++) begin
      ref_in = 1'b1;
      repeat (hi) @(negedge clk);
      ref_in = 1'b0;
      repeat (per - hi) @(negedge clk);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "code", code, 0);
    chk("R1", "valid", valid, 0);
    chk("R1", "coarse", cf, 0);
    chk("R1", "cycle", sc, 0);
    rst_n = 1'b1;

    // dead reference from reset: limit 2*2000
    repeat (4200) @(negedge clk);
    chk("R8", "dead sc", sc, 1);
    chk("R8", "dead valid", valid, 0);
    chk("R10", "dead coarse", cf, 0);

    for (int v = 0; v < 7; v++) begin
      int n;
      n = (6000 / VEC[v].per > 12) ? 6000 / VEC[v].per : 12;
      drive(VEC[v].per, VEC[v].hi, n);
      chk("R3", $sformatf("vec%0d code", v), code, VEC[v].code);
      chk("R4", $sformatf("vec%0d valid", v), valid, 1);
      chk("R9", $sformatf("vec%0d cycle", v), sc, 0);
      chk("R9", $sformatf("vec%0d coarse", v), cf, 0);
    end
    chk("R2", "one-cycle pulse rate", code, 7);

    // loss while valid at rate 7 (limit 24)
    repeat (40) @(negedge clk);
    chk("R8", "loss sc", sc, 1);
    chk("R8", "loss valid", valid, 0);
    chk("R8", "loss code", code, 0);

    // re-detect: one measured period is not enough
    drive(24, 12, 2);
    chk("R4", "one match valid", valid, 0);
    drive(24, 12, 1);
    chk("R4", "two matches valid", valid, 1);
    chk("R4", "two matches code", code, 5);
    drive(24, 12, 12);
    chk("R9", "sc cleared after redetect", sc, 0);

    // long single period
    drive(40, 12, 1);
    drive(24, 12, 4);
    chk("R7", "long hit sc", sc, 1);
    chk("R10", "long hit coarse", cf, 0);
    chk("R9", "three goods still set", sc, 1);
    drive(24, 12, 1);
    chk("R9", "fourth good clears", sc, 0);

    // short single period
    drive(10, 5, 1);
    drive(24, 12, 1);
    chk("R7", "short hit sc", sc, 1);
    drive(24, 12, 8);
    chk("R9", "short hit cleared", sc, 0);

    // window check: 25 % slow at rate 5
    drive(30, 15, 100);
    chk("R5", "slow window coarse", cf, 1);
    chk("R10", "slow window cycle", sc, 0);
    chk("R3", "unmatched keeps code", code, 5);
    chk("R3", "unmatched keeps valid", valid, 1);
    drive(24, 12, 250);
    chk("R9", "window recover", cf, 0);

    // period fallback at 2 kHz
    drive(2000, 1000, 10);
    chk("R3", "slow code", code, 1);
    chk("R9", "slow sc clear", sc, 0);
    drive(2400, 1200, 2);
    chk("R6", "fallback coarse", cf, 1);
    chk("R10", "fallback cycle", sc, 0);
    chk("R6", "fallback code", code, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule